// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block runs program and erase operations on a NOR flash that reports progress through a readable status word. The host places one request at a time: a single-word program, a block erase, or a buffered program of several words. The block then issues the flash write cycles, polls status until every chip on the bus reports ready, and judges the error bits that belong to the operation. It then clears status and returns the flash to read-array mode. Every operation finishes with a one-cycle done pulse and a two-bit result.

The flash bus may be built from several chips side by side. Each chip has an operating width of `CHIP_W` bits. A command byte goes on the lowest byte of every chip lane, and the rest of each lane is zero. Status is read per lane. The flash counts as ready only when all lanes show bit 7. An error bit in any lane fails the operation. An erase always starts with a block unlock and checks the lock status before it erases. A buffered program repeats its load command until the flash accepts it, and gives up after `LOAD_TRIES` attempts. Each write or read strobe lasts one clock. Read data is sampled on the edge that ends the read cycle.

States: IDLE (accept request), PROG_CMD, PROG_DATA, UNLK_SETUP, UNLK_CONF, ERASE_SETUP, ERASE_CONF, LOAD_CMD, LOAD_POLL, WCOUNT, WDATA, BCONF, POLL, CLEAR, RESET, DONE. The transitions are:

- IDLE goes to PROG_CMD for a program, to UNLK_SETUP for an erase, to LOAD_CMD for a buffered program, and straight to DONE for an unsupported op.
- PROG_CMD goes to PROG_DATA and then to POLL.
- UNLK_SETUP goes to UNLK_CONF and then to POLL. ERASE_SETUP goes to ERASE_CONF and then to POLL.
- LOAD_CMD goes to LOAD_POLL. LOAD_POLL goes to WCOUNT when the flash is ready, to CLEAR when the attempt limit is reached, and back to LOAD_CMD otherwise.
- WCOUNT goes to WDATA. WDATA stays in WDATA until the last word is written, then goes to BCONF, and BCONF goes to POLL.
- POLL stays in POLL while the flash is busy and goes to CLEAR when it is ready.
- CLEAR goes to RESET. RESET goes to ERASE_SETUP after a passing unlock, and to DONE otherwise. DONE goes to IDLE.

Top module: `nor_seq_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `fl_we`, `fl_re` and `done` are 0.
- R2: The program sequence (op 0) is as follows. Write command 0x40 to `req_addr`. Write `req_data` to `req_addr`. Read status until it is ready. Write 0x50, then write 0xFF. Then raise done.
- R3: A program returns fail (1) if bit 4 or bit 3 is set in any chip lane of the final status. Otherwise it returns pass (0).
- R4: An erase (op 1) first writes 0x60 and then 0xD0 to `req_addr`, and polls status. If bit 5 or bit 3 is set, it writes 0x50 and then 0xFF and returns fail without erasing.
- R5: When the unlock passes, the erase writes 0x50 and 0xFF, then writes 0x20 and 0xD0 to `req_addr`. It polls status, writes 0x50 and 0xFF, and returns fail only if bit 5 is set. Bit 4 alone does not fail an erase.
- R6: A buffered program (op 2) writes 0xE8 to `req_addr` and then reads status once. It repeats this pair until status is ready. After `LOAD_TRIES` attempts that are not ready, it writes 0x50 and 0xFF and returns timeout (2).
- R7: After a load is accepted, the buffered program writes one command byte, (`req_bytes` >> log2(`DATA_W`/8)) − 1. Next, for each i from 0 upward, it writes `buf_word` to `req_addr`+i with `buf_idx`=i. It then writes 0xD0 to `req_addr`, polls status, and writes 0x50 and 0xFF. It returns fail if bit 4 is set.
- R8: Each command word carries the command byte in bits [c·`CHIP_W`+7 : c·`CHIP_W`] of every chip lane c, and zero in all other bits.
- R9: Status counts as ready only when bit 7 (bit c·`CHIP_W`+7) is set in every chip lane. An error bit in any single lane counts as an error.
- R10: `done` is high for exactly one cycle, carrying the result: 0 pass, 1 fail, 2 timeout. It is raised in the cycle after the final 0xFF write. `req_ready` is high only in idle, and a request raised while an operation runs is ignored.
- R11: Op code 3 is unsupported. It gives done with result fail in the cycle after acceptance, with no flash cycles.
- R12: `fl_we` and `fl_re` are never high together. The block reads the flash only in the status poll states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_op | input | 2 | 0 program, 1 erase, 2 buffered program, 3 unsupported |
| req_addr | input | ADDR_W | Target word address (block address for erase) |
| req_data | input | DATA_W | Data word for single-word program |
| req_bytes | input | CNT_W | Byte count for buffered program |
| req_ready | output | 1 | Sequencer idle |
| buf_idx | output | CNT_W | Index of the buffered word currently written |
| buf_word | input | DATA_W | Buffered data word for index buf_idx, same cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 pass, 1 fail, 2 timeout; valid with done |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we | output | 1 | One-cycle flash write strobe |
| fl_re | output | 1 | One-cycle flash read strobe |
| fl_rdata | input | DATA_W | Flash read data, sampled at the end of a read cycle |

## Verification
The first flash cycle of an operation appears in the cycle after the request is accepted. After that, each flash write or status read takes exactly one cycle. Done is therefore due in cycle W+R+1 after acceptance, where W is the number of writes and R the number of reads. The bench counts each cycle from acceptance at the falling edge. It checks every write against a queue of expected address and data pairs built from the requirements. It counts the reads and compares them with the busy time its flash model was given. It also checks that done lands on cycle W+R+1 and falls one cycle later.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG    = 2'd0,
        OP_ERASE   = 2'd1,
        OP_BUFPROG = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_PASS    = 2'd0,
        RES_FAIL    = 2'd1,
        RES_TIMEOUT = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        STG_PROG,
        STG_UNLOCK,
        STG_ERASE,
        STG_BUF
    } stage_e;

    localparam logic [7:0] CMD_PROGRAM      = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_UNLOCK_SETUP = 8'h60;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_BUF_LOAD     = 8'hE8;
    localparam logic [7:0] CMD_CLR_STAT     = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;

    // error bits judged per stage
    localparam logic [7:0] ERRM_PROG   = 8'h18;  // bits 4,3
    localparam logic [7:0] ERRM_UNLOCK = 8'h28;  // bits 5,3
    localparam logic [7:0] ERRM_ERASE  = 8'h20;  // bit 5
    localparam logic [7:0] ERRM_BUF    = 8'h10;  // bit 4

endpackage

// File: rtl/nor_lane_fmt.sv
module nor_lane_fmt #(
    parameter int DATA_W = 16,
    parameter int CHIP_W = 8
) (
    input  logic [7:0]        cmd,
    output logic [DATA_W-1:0] word
);
    localparam int NCHIP = DATA_W / CHIP_W;

    for (genvar c = 0; c < NCHIP; c++) begin : g_lane
        assign word[c*CHIP_W +: 8] = cmd;
        if (CHIP_W > 8) begin : g_pad
            assign word[c*CHIP_W+8 +: CHIP_W-8] = '0;
        end
    end
endmodule

// File: rtl/nor_stat_eval.sv
module nor_stat_eval #(
    parameter int DATA_W = 16,
    parameter int CHIP_W = 8
) (
    input  logic [DATA_W-1:0] stat,
    input  logic [7:0]        err_mask,
    output logic              all_ready,
    output logic              any_err
);
    localparam int NCHIP = DATA_W / CHIP_W;

    logic [NCHIP-1:0] lane_rdy;
    logic [NCHIP-1:0] lane_err;

    for (genvar c = 0; c < NCHIP; c++) begin : g_lane
        assign lane_rdy[c] = stat[c*CHIP_W + 7];
        assign lane_err[c] = |(stat[c*CHIP_W +: 8] & err_mask);
    end

    assign all_ready = &lane_rdy;
    assign any_err   = |lane_err;
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
    import nor_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CHIP_W     = 8,
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 10,
    parameter int LOAD_TRIES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CNT_W-1:0]  req_bytes,
    output logic              req_ready,
    output logic [CNT_W-1:0]  buf_idx,
    input  logic [DATA_W-1:0] buf_word,
    output logic              done,
    output logic [1:0]        result,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam int SHIFT = $clog2(DATA_W / 8);
    localparam int TRY_W = $clog2(LOAD_TRIES + 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(LOAD_TRIES - 1);

    typedef enum logic [3:0] {
        S_IDLE, S_PROG_CMD, S_PROG_DATA, S_UNLK_SETUP, S_UNLK_CONF,
        S_ERASE_SETUP, S_ERASE_CONF, S_LOAD_CMD, S_LOAD_POLL, S_WCOUNT,
        S_WDATA, S_BCONF, S_POLL, S_CLEAR, S_RESET, S_DONE
    } state_e;

    state_e              state, nstate;
    stage_e              stage;
    logic [ADDR_W-1:0]   addr_r;
    logic [DATA_W-1:0]   data_r;
    logic [CNT_W-1:0]    words_r;
    logic [CNT_W-1:0]    idx;
    logic [TRY_W-1:0]    tries;
    logic [1:0]          res_r;
    logic                more_r;

    logic [7:0]          cmd_byte;
    logic [7:0]          err_mask;
    logic [DATA_W-1:0]   cmd_word;
    logic                use_data, use_buf;
    logic                st_ready, st_err;
    logic [CNT_W+7:0]    cnt_ext;

    assign cnt_ext = {8'd0, words_r - CNT_W'(1)};

    nor_lane_fmt #(.DATA_W(DATA_W), .CHIP_W(CHIP_W)) u_fmt (
        .cmd  (cmd_byte),
        .word (cmd_word)
    );

    nor_stat_eval #(.DATA_W(DATA_W), .CHIP_W(CHIP_W)) u_stat (
        .stat      (fl_rdata),
        .err_mask  (err_mask),
        .all_ready (st_ready),
        .any_err   (st_err)
    );

    always_comb begin
        unique case (stage)
            STG_PROG:   err_mask = ERRM_PROG;
            STG_UNLOCK: err_mask = ERRM_UNLOCK;
            STG_ERASE:  err_mask = ERRM_ERASE;
            STG_BUF:    err_mask = ERRM_BUF;
            default:    err_mask = ERRM_PROG;
        endcase
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    unique case (op_e'(req_op))
                        OP_PROG:    nstate = S_PROG_CMD;
                        OP_ERASE:   nstate = S_UNLK_SETUP;
                        OP_BUFPROG: nstate = S_LOAD_CMD;
                        default:    nstate = S_DONE;
                    endcase
                end
            end
            S_PROG_CMD:    nstate = S_PROG_DATA;
            S_PROG_DATA:   nstate = S_POLL;
            S_UNLK_SETUP:  nstate = S_UNLK_CONF;
            S_UNLK_CONF:   nstate = S_POLL;
            S_ERASE_SETUP: nstate = S_ERASE_CONF;
            S_ERASE_CONF:  nstate = S_POLL;
            S_LOAD_CMD:    nstate = S_LOAD_POLL;
            S_LOAD_POLL: begin
                if (st_ready)               nstate = S_WCOUNT;
                else if (tries == TRY_LAST) nstate = S_CLEAR;
                else                        nstate = S_LOAD_CMD;
            end
            S_WCOUNT:      nstate = S_WDATA;
            S_WDATA:       nstate = (idx == words_r - CNT_W'(1)) ? S_BCONF : S_WDATA;
            S_BCONF:       nstate = S_POLL;
            S_POLL:        nstate = st_ready ? S_CLEAR : S_POLL;
            S_CLEAR:       nstate = S_RESET;
            S_RESET:       nstate = more_r ? S_ERASE_SETUP : S_DONE;
            S_DONE:        nstate = S_IDLE;
            default:       nstate = S_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            stage   <= STG_PROG;
            addr_r  <= '0;
            data_r  <= '0;
            words_r <= '0;
            idx     <= '0;
            tries   <= '0;
            res_r   <= RES_PASS;
            more_r  <= 1'b0;
        end else begin
            state <= nstate;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    addr_r  <= req_addr;
                    data_r  <= req_data;
                    words_r <= req_bytes >> SHIFT;
                    idx     <= '0;
                    tries   <= '0;
                    more_r  <= 1'b0;
                    res_r   <= (op_e'(req_op) == OP_NONE) ? RES_FAIL : RES_PASS;
                    unique case (op_e'(req_op))
                        OP_ERASE:   stage <= STG_UNLOCK;
                        OP_BUFPROG: stage <= STG_BUF;
                        default:    stage <= STG_PROG;
                    endcase
                end
                S_LOAD_POLL: if (!st_ready) begin
                    if (tries == TRY_LAST) res_r <= RES_TIMEOUT;
                    else                   tries <= tries + TRY_W'(1);
                end
                S_WDATA: idx <= idx + CNT_W'(1);
                S_POLL: if (st_ready) begin
                    if (st_err)                  res_r  <= RES_FAIL;
                    else if (stage == STG_UNLOCK) more_r <= 1'b1;
                end
                S_RESET: if (more_r) begin
                    more_r <= 1'b0;
                    stage  <= STG_ERASE;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fl_we     = 1'b0;
        fl_re     = 1'b0;
        req_ready = 1'b0;
        done      = 1'b0;
        use_data  = 1'b0;
        use_buf   = 1'b0;
        cmd_byte  = CMD_READ_ARRAY;
        unique case (state)
            S_IDLE:        req_ready = 1'b1;
            S_PROG_CMD:    begin fl_we = 1'b1; cmd_byte = CMD_PROGRAM;      end
            S_PROG_DATA:   begin fl_we = 1'b1; use_data = 1'b1;             end
            S_UNLK_SETUP:  begin fl_we = 1'b1; cmd_byte = CMD_UNLOCK_SETUP; end
            S_UNLK_CONF:   begin fl_we = 1'b1; cmd_byte = CMD_CONFIRM;      end
            S_ERASE_SETUP: begin fl_we = 1'b1; cmd_byte = CMD_ERASE_SETUP;  end
            S_ERASE_CONF:  begin fl_we = 1'b1; cmd_byte = CMD_CONFIRM;      end
            S_LOAD_CMD:    begin fl_we = 1'b1; cmd_byte = CMD_BUF_LOAD;     end
            S_LOAD_POLL:   fl_re = 1'b1;
            S_WCOUNT:      begin fl_we = 1'b1; cmd_byte = cnt_ext[7:0];     end
            S_WDATA:       begin fl_we = 1'b1; use_buf = 1'b1;              end
            S_BCONF:       begin fl_we = 1'b1; cmd_byte = CMD_CONFIRM;      end
            S_POLL:        fl_re = 1'b1;
            S_CLEAR:       begin fl_we = 1'b1; cmd_byte = CMD_CLR_STAT;     end
            S_RESET:       begin fl_we = 1'b1; cmd_byte = CMD_READ_ARRAY;   end
            S_DONE:        done = 1'b1;
            default: ;
        endcase
    end

    assign fl_addr  = use_buf ? addr_r + ADDR_W'(idx) : addr_r;
    assign fl_wdata = use_data ? data_r : (use_buf ? buf_word : cmd_word);
    assign buf_idx  = idx;
    assign result   = res_r;

    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re)); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!fl_we && !fl_re && !done)); // R10

    AST_PASS_AFTER_RD_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_PASS) |-> ($past(fl_we) && $past(fl_wdata[7:0]) == CMD_READ_ARRAY)); // R2

    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_LAST); // R6

    AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3)); // R10

endmodule

// File: tb/sim_nor_seq_ctrl.sv
`timescale 1ns/1ps
module sim_nor_seq_ctrl;
    localparam int DATA_W = 32;
    localparam int CHIP_W = 16;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;
    localparam int TRIES  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [CNT_W-1:0]  req_bytes = '0;
    logic              req_ready, done, fl_we, fl_re;
    logic [CNT_W-1:0]  buf_idx;
    logic [DATA_W-1:0] buf_word, fl_wdata, fl_rdata;
    logic [1:0]        result;
    logic [ADDR_W-1:0] fl_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    nor_seq_ctrl #(.DATA_W(DATA_W), .CHIP_W(CHIP_W), .ADDR_W(ADDR_W),
                   .CNT_W(CNT_W), .LOAD_TRIES(TRIES)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_bytes(req_bytes),
        .req_ready(req_ready), .buf_idx(buf_idx), .buf_word(buf_word),
        .done(done), .result(result), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    assign buf_word = 32'hC0DE_0000 | {24'd0, buf_idx};

    // command byte on low byte of each 16-bit chip lane (R8)
    function automatic logic [31:0] lanes(input logic [7:0] b);
        return {8'h00, b, 8'h00, b};
    endfunction

    // ---------------- behavioural flash model ----------------
    int         busy_cfg  = 0;
    logic [1:0] busy_mask = 2'b11;
    logic [7:0] err_lane [2];
    int         err_after = 0;
    int         d0_base   = 0;
    int         busy_left = 0;
    int         d0_cnt    = 0;

    initial begin err_lane[0] = 8'h00; err_lane[1] = 8'h00; end

    always @(posedge clk) begin
        if (fl_we) begin
            busy_left <= busy_cfg;
            if (fl_wdata == lanes(8'hD0)) d0_cnt <= d0_cnt + 1;
        end else if (fl_re && busy_left > 0) begin
            busy_left <= busy_left - 1;
        end
    end

    always_comb begin
        for (int c = 0; c < 2; c++) begin
            logic [7:0] s;
            s = (busy_left > 0 && busy_mask[c]) ? 8'h00 : 8'h80;
            if (d0_cnt - d0_base >= err_after) s = s | err_lane[c];
            fl_rdata[c*16 +: 16] = {8'h00, s};
        end
    end

    // ---------------- expected write queue ----------------
    logic [47:0] expq [$];

    task automatic push(input logic [15:0] a, input logic [31:0] d);
        expq.push_back({a, d});
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] addr,
                          input logic [31:0] data, input logic [7:0] nbytes,
                          input logic [1:0] exp_res, input int exp_reads,
                          input int poke_at, input string req);
        int cyc, nw, nr;
        bit got;
        logic [47:0] e;
        d0_base = d0_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_data = data; req_bytes = nbytes;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; nw = 0; nr = 0; got = 0;
        forever begin
            if (cyc == poke_at) begin
                req_valid = 1'b1; req_op = 2'd1; req_addr = 16'hFFFF;
            end else if (cyc == poke_at + 1) begin
                req_valid = 1'b0;
            end
            if (fl_we && fl_re) chk(0, "R12", "we and re together", 48'd1, 48'd0);
            if (fl_we) begin
                nw++;
                if (expq.size() == 0) begin
                    chk(0, req, "unexpected write", {fl_addr, fl_wdata}, 48'd0);
                end else begin
                    e = expq.pop_front();
                    chk({fl_addr, fl_wdata} == e, req, "write cycle", {fl_addr, fl_wdata}, e);
                end
            end
            if (fl_re) nr++;
            if (done) begin got = 1; break; end
            if (cyc > 400) break;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(got, "R10", "done seen", {47'd0, got}, 48'd1);
        chk(result == exp_res, req, "result", {46'd0, result}, {46'd0, exp_res});
        chk(nr == exp_reads, req, "status reads", 48'(nr), 48'(exp_reads));
        chk(expq.size() == 0, req, "writes left over", 48'(expq.size()), 48'd0);
        chk(cyc == nw + nr + 1, "R10", "done cycle", 48'(cyc), 48'(nw + nr + 1));
        expq.delete();
        @(negedge clk);
        chk(!done && req_ready, "R10", "done one cycle then idle",
            {46'd0, done, req_ready}, 48'd1);
    endtask

    task automatic tail_ok(input logic [15:0] a);
        push(a, lanes(8'h50));
        push(a, lanes(8'hFF));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !fl_we && !fl_re && !done, "R1", "in reset",
            {44'd0, req_ready, fl_we, fl_re, done}, 48'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !fl_we && !fl_re && !done, "R1", "after reset",
            {44'd0, req_ready, fl_we, fl_re, done}, 48'h8);

        // R2 R8: program pass
        busy_cfg = 3; err_after = 0;
        push(16'h0100, lanes(8'h40)); push(16'h0100, 32'h1234_ABCD); tail_ok(16'h0100);
        run_op(2'd0, 16'h0100, 32'h1234_ABCD, 8'd0, 2'd0, 4, -5, "R2");

        // R3 R9: bit 4 in upper lane only
        busy_cfg = 1; err_lane[1] = 8'h10;
        push(16'h0200, lanes(8'h40)); push(16'h0200, 32'h0000_5555); tail_ok(16'h0200);
        run_op(2'd0, 16'h0200, 32'h0000_5555, 8'd0, 2'd1, 2, -5, "R3");

        // R3: bit 3 in lower lane
        err_lane[1] = 8'h00; err_lane[0] = 8'h08;
        push(16'h0201, lanes(8'h40)); push(16'h0201, 32'hFFFF_0000); tail_ok(16'h0201);
        run_op(2'd0, 16'h0201, 32'hFFFF_0000, 8'd0, 2'd1, 2, -5, "R3");
        err_lane[0] = 8'h00;

        // R9: only upper chip stays busy, lower already ready
        busy_cfg = 4; busy_mask = 2'b10;
        push(16'h0300, lanes(8'h40)); push(16'h0300, 32'h0A0B_0C0D); tail_ok(16'h0300);
        run_op(2'd0, 16'h0300, 32'h0A0B_0C0D, 8'd0, 2'd0, 5, -5, "R9");
        busy_mask = 2'b11;

        // R10: request raised mid-operation is ignored
        busy_cfg = 5;
        push(16'h0400, lanes(8'h40)); push(16'h0400, 32'h7777_8888); tail_ok(16'h0400);
        run_op(2'd0, 16'h0400, 32'h7777_8888, 8'd0, 2'd0, 6, 3, "R10");

        // R4 R5: erase pass
        busy_cfg = 2;
        push(16'h1000, lanes(8'h60)); push(16'h1000, lanes(8'hD0)); tail_ok(16'h1000);
        push(16'h1000, lanes(8'h20)); push(16'h1000, lanes(8'hD0)); tail_ok(16'h1000);
        run_op(2'd1, 16'h1000, 32'd0, 8'd0, 2'd0, 6, -5, "R5");

        // R4: unlock fails on bit 3, erase skipped
        err_lane[0] = 8'h08; err_after = 0;
        push(16'h1100, lanes(8'h60)); push(16'h1100, lanes(8'hD0)); tail_ok(16'h1100);
        run_op(2'd1, 16'h1100, 32'd0, 8'd0, 2'd1, 3, -5, "R4");

        // R5: erase stage fails on bit 5 (shown only after second confirm)
        err_lane[0] = 8'h00; err_lane[1] = 8'h20; err_after = 2;
        push(16'h1200, lanes(8'h60)); push(16'h1200, lanes(8'hD0)); tail_ok(16'h1200);
        push(16'h1200, lanes(8'h20)); push(16'h1200, lanes(8'hD0)); tail_ok(16'h1200);
        run_op(2'd1, 16'h1200, 32'd0, 8'd0, 2'd1, 6, -5, "R5");

        // R5: bit 4 alone does not fail an erase
        err_lane[1] = 8'h10; err_after = 0;
        push(16'h1300, lanes(8'h60)); push(16'h1300, lanes(8'hD0)); tail_ok(16'h1300);
        push(16'h1300, lanes(8'h20)); push(16'h1300, lanes(8'hD0)); tail_ok(16'h1300);
        run_op(2'd1, 16'h1300, 32'd0, 8'd0, 2'd0, 6, -5, "R5");
        err_lane[1] = 8'h00;

        // R7: buffered program 16 bytes -> 4 words, count 3
        busy_cfg = 0;
        push(16'h2000, lanes(8'hE8)); push(16'h2000, lanes(8'h03));
        for (int i = 0; i < 4; i++) push(16'h2000 + 16'(i), 32'hC0DE_0000 | i);
        push(16'h2000, lanes(8'hD0)); tail_ok(16'h2000);
        run_op(2'd2, 16'h2000, 32'd0, 8'd16, 2'd0, 2, -5, "R7");

        // R7: 6 bytes -> 1 word, count 0, bit 4 fails it
        err_lane[0] = 8'h10;
        push(16'h2100, lanes(8'hE8)); push(16'h2100, lanes(8'h00));
        push(16'h2100, 32'hC0DE_0000);
        push(16'h2100, lanes(8'hD0)); tail_ok(16'h2100);
        run_op(2'd2, 16'h2100, 32'd0, 8'd6, 2'd1, 2, -5, "R7");
        err_lane[0] = 8'h00;

        // R6: load never accepted -> timeout after TRIES attempts
        busy_cfg = 1;
        for (int i = 0; i < TRIES; i++) push(16'h2200, lanes(8'hE8));
        tail_ok(16'h2200);
        run_op(2'd2, 16'h2200, 32'd0, 8'd16, 2'd2, TRIES, -5, "R6");

        // R11: unsupported op
        run_op(2'd3, 16'h3000, 32'd0, 8'd0, 2'd1, 0, -5, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule